// File: doc/BRIEF.md
# Audio Subsystem Interval Timer Bank

This block is a set of three interval timers for the audio coprocessor. It runs on the subsystem clock. Software reaches it through a small register port made of a write strobe, a read strobe, an 8-bit address and 8-bit data. Each timer has three stages: a free-running prescaler, an 8-bit divider that counts prescaler ticks up to a programmed target, and a 4-bit event counter that advances each time the divider matches. The two slow timers tick once every 128 clocks. The fast timer ticks once every 16 clocks.

Software polls a timer by reading its event counter. The read returns the number of periods since the last read, and the same access clears the counter. One control register holds an enable bit for each timer. Setting a bit restarts that timer from zero. Writing a bit that is already set leaves the timer running undisturbed.

Each channel is controlled by a two-state machine. In `TMR_OFF` the divider and counter hold. In `TMR_RUN` the divider counts prescaler ticks. The transition `OFF->RUN` is taken on a control write whose enable bit is 1, and it clears the divider and counter. The transition `RUN->OFF` is taken on a control write whose enable bit is 0. A control write that does not change a channel's enable bit leaves that channel in its state.

Top module: `audio_timer_bank`

## Requirements
- R1: After reset, every prescaler, divider, target, counter and enable is zero, so reads of 0xFD, 0xFE and 0xFF return 0.
- R2: Timers 0 and 1 get a prescaler tick on the clock edges numbered 0, 128, 256, and so on. Timer 2 gets one on edges 0, 16, 32, and so on. Edges are counted from the first rising edge after reset is released.
- R3: On each tick of a running timer, its divider increments. When the incremented value equals the target, the divider becomes 0 and the counter increments. As a result, the counter advances once per target ticks.
- R4: A target of 0 behaves as 256 ticks per counter step.
- R5: The counter is 4 bits wide and wraps from 15 to 0.
- R6: A read of the counter address (0xFD, 0xFE or 0xFF for timers 0, 1 and 2) returns the current count and clears it to 0 at that clock edge.
- R7: If a read and a counter increment fall on the same edge, the read returns the old value and the counter then holds 1.
- R8: In the control register at 0xF1, bit n enables timer n. A 0-to-1 change clears that timer's divider and counter, and the tick on that edge is not counted. A bit written as 1 while it is already 1 clears nothing.
- R9: A disabled timer holds its divider and counter. Its prescaler keeps its phase, so a timer enabled later follows the tick grid of R2.
- R10: Targets are written at 0xFA, 0xFB and 0xFC. A read of any address other than 0xFD to 0xFF, including the target addresses, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subsystem clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a counter read clears the counter at the edge |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as rd_en; 0 when no counter is addressed |

## Verification
The hardest case to reach from the ports is the read that lands on the same edge as a counter increment. The stimulus reaches it in steps. It sets the fast timer's target to 1, so the counter increments on every tick. It then counts edges since reset, waits for an edge index that is a multiple of 16, and issues the read there. A second read in the next cycle shows the leftover 1. Prescaler phase continuity is checked by re-enabling a timer on an edge that is not aligned to the tick grid and comparing the count against ticks predicted from reset.

// File: rtl/audio_timer_pkg.sv
package audio_timer_pkg;

    typedef enum logic {
        TMR_OFF = 1'b0,
        TMR_RUN = 1'b1
    } tmr_state_e;

    // Prescaler period for channel idx: the last channel is the fast one.
    function automatic int period_for(input int idx, input int count,
                                      input int slow, input int fast);
        return (idx == count - 1) ? fast : slow;
    endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int PERIOD = 128
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = (pre_q == '0);

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import audio_timer_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic             tgt_wr,
    input  logic [DIV_W-1:0] tgt_data,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    tmr_state_e       state_q, state_d;
    logic [DIV_W-1:0] tgt_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_next;
    logic [CNT_W-1:0] cnt_q;
    logic             arm;
    logic             step;
    logic             hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_OFF: if (ctl_wr && ctl_en)  state_d = TMR_RUN;
            TMR_RUN: if (ctl_wr && !ctl_en) state_d = TMR_OFF;
            default: state_d = TMR_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_OFF;
        else        state_q <= state_d;
    end

    assign arm      = (state_q == TMR_OFF) && ctl_wr && ctl_en;
    assign step     = (state_q == TMR_RUN) && tick;
    assign div_next = div_q + 1'b1;
    assign hit      = step && (div_next == tgt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            div_q <= '0;
            cnt_q <= '0;
        end else begin
            if (tgt_wr) tgt_q <= tgt_data;

            if (arm)       div_q <= '0;
            else if (step) div_q <= hit ? '0 : div_next;

            if (arm)         cnt_q <= '0;
            else if (cnt_rd) cnt_q <= hit ? CNT_W'(1) : '0;
            else if (hit)    cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        count   = cnt_q;
        running = (state_q == TMR_RUN);
    end

endmodule

// File: rtl/audio_timer_bank.sv
module audio_timer_bank
    import audio_timer_pkg::*;
#(
    parameter int              NUM_TMR   = 3,
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              DIV_W     = 8,
    parameter int              CNT_W     = 4,
    parameter int              SLOW_PRE  = 128,
    parameter int              FAST_PRE  = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF1,
    parameter logic [ADDR_W-1:0] TGT_BASE  = 8'hFA,
    parameter logic [ADDR_W-1:0] CNT_BASE  = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic                          ctl_wr;
    logic [NUM_TMR-1:0]            tgt_wr;
    logic [NUM_TMR-1:0]            cnt_rd;
    logic [NUM_TMR-1:0]            tick;
    logic [NUM_TMR-1:0]            en_q;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q;

    assign ctl_wr = wr_en && (addr == CTRL_ADDR);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam int P = period_for(i, NUM_TMR, SLOW_PRE, FAST_PRE);

        assign tgt_wr[i] = wr_en && (addr == ADDR_W'(int'(TGT_BASE) + i));
        assign cnt_rd[i] = rd_en && (addr == ADDR_W'(int'(CNT_BASE) + i));

        timer_prescaler #(.PERIOD(P)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick[i])
        );

        timer_channel #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick[i]),
            .ctl_wr   (ctl_wr),
            .ctl_en   (wdata[i]),
            .tgt_wr   (tgt_wr[i]),
            .tgt_data (wdata[DIV_W-1:0]),
            .cnt_rd   (cnt_rd[i]),
            .count    (cnt_q[i]),
            .running  (en_q[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (cnt_rd[i]) rdata = DATA_W'(cnt_q[i]);
        end
    end

endmodule

// File: rtl/audio_timer_bank_chk.sv
module audio_timer_bank_chk #(
    parameter int              NUM_TMR   = 3,
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              CNT_W     = 4,
    parameter int              SLOW_PRE  = 128,
    parameter int              FAST_PRE  = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF1,
    parameter logic [ADDR_W-1:0] CNT_BASE  = 8'hFD
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [NUM_TMR-1:0]            ctl_bits,
    input logic [DATA_W-1:0]             rdata,
    input logic [NUM_TMR-1:0]            tick,
    input logic [NUM_TMR-1:0]            en_q,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q
);
    // R10: anything but a counter address reads as zero
    assert_other_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(addr) < int'(CNT_BASE) || int'(addr) >= int'(CNT_BASE) + NUM_TMR))
        |-> (rdata == '0));

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        localparam int P = (i == NUM_TMR - 1) ? FAST_PRE : SLOW_PRE;
        logic [15:0] gap_q;
        logic        seen_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q  <= '0;
                seen_q <= 1'b0;
            end else if (tick[i]) begin
                gap_q  <= 16'd1;
                seen_q <= 1'b1;
            end else begin
                gap_q  <= gap_q + 1'b1;
            end
        end

        // R2: spacing between prescaler ticks
        assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[i] && seen_q) |-> (int'(gap_q) == P));

        // R5: without register access the counter holds or steps by one, wrapping
        assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_en && !wr_en) |=>
            ((cnt_q[i] == $past(cnt_q[i])) || (cnt_q[i] == $past(cnt_q[i]) + 1'b1)));

        // R6 / R7: after a read the counter is 0, or 1 on a collision
        assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == ADDR_W'(int'(CNT_BASE) + i)) |=> (cnt_q[i] <= CNT_W'(1)));

        // R8: an enable rising edge clears the counter
        assert_enable_edge_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CTRL_ADDR && ctl_bits[i] && !en_q[i]) |=> (cnt_q[i] == '0));

        // R9: a disabled timer holds its counter
        assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[i] && !wr_en && !rd_en) |=> $stable(cnt_q[i]));
    end

endmodule

bind audio_timer_bank audio_timer_bank_chk #(
    .NUM_TMR   (NUM_TMR),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .SLOW_PRE  (SLOW_PRE),
    .FAST_PRE  (FAST_PRE),
    .CTRL_ADDR (CTRL_ADDR),
    .CNT_BASE  (CNT_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .ctl_bits (wdata[NUM_TMR-1:0]),
    .rdata    (rdata),
    .tick     (tick),
    .en_q     (en_q),
    .cnt_q    (cnt_q)
);

// File: tb/audio_timer_bank_test.sv
module audio_timer_bank_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int  n_vec = 0;
    int  n_bad = 0;
    int  edge_n = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_timer_bank uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    // Index of the next rising edge, counted from reset release.
    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    // Counter increments on edges in (e, x) for a timer enabled at edge e.
    function automatic int incs(input int e, input int x, input int n, input int t);
        int tt = (t == 0) ? 256 : t;
        int tk;
        if (x - 1 < e) return 0;
        tk = (x - 1) / n - e / n;
        return tk / tt;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input int exp);
        n_vec++;
        if (act !== 8'(exp)) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output int at);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        at    = edge_n;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v, output int at);
        addr  = a;
        rd_en = 1'b1;
        #1;
        v  = rdata;
        at = edge_n;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_to(input int k);
        while (edge_n < k) @(negedge clk);
    endtask

    // R1 and R10: reset values and zero reads of non-counter addresses
    task automatic t_reset_and_zero_reads();
        logic [7:0] v;
        int at;
        do_reset();
        rd(8'hFD, v, at); chk("R1 cnt0 after reset", v, 0);
        rd(8'hFE, v, at); chk("R1 cnt1 after reset", v, 0);
        rd(8'hFF, v, at); chk("R1 cnt2 after reset", v, 0);
        wr(8'hFA, 8'h5A, at);
        wr(8'hFC, 8'hC3, at);
        rd(8'hFA, v, at); chk("R10 target0 read", v, 0);
        rd(8'hFC, v, at); chk("R10 target2 read", v, 0);
        rd(8'hF1, v, at); chk("R10 control read", v, 0);
    endtask

    // R2, R3, R6: fast timer with target 3, read twice
    task automatic t_fast_divide();
        logic [7:0] v;
        int at, e, r1;
        do_reset();
        wr(8'hFC, 8'd3, at);
        wr(8'hF1, 8'h04, e);
        wait_to(e + 16 * 10 + 5);
        rd(8'hFF, v, r1); chk("R3 timer2 target 3", v, incs(e, r1, 16, 3) & 15);
        rd(8'hFF, v, at); chk("R6 timer2 cleared by read", v, (incs(e, at, 16, 3) - incs(e, r1, 16, 3)) & 15);
    endtask

    // R2: slow timer period
    task automatic t_slow_divide();
        logic [7:0] v;
        int at, e, r;
        do_reset();
        wr(8'hFA, 8'd2, at);
        wr(8'hF1, 8'h01, e);
        wait_to(e + 128 * 7 + 3);
        rd(8'hFD, v, r); chk("R2 timer0 slow prescaler", v, incs(e, r, 128, 2) & 15);
    endtask

    // R5: wrap beyond 15
    task automatic t_wrap();
        logic [7:0] v;
        int at, e, r;
        do_reset();
        wr(8'hFC, 8'd1, at);
        wr(8'hF1, 8'h04, e);
        wait_to(e + 16 * 19 + 2);
        rd(8'hFF, v, r); chk("R5 counter wrap", v, incs(e, r, 16, 1) & 15);
    endtask

    // R4: target 0 means 256 ticks
    task automatic t_target_zero();
        logic [7:0] v;
        int at, e, r;
        do_reset();
        wr(8'hFC, 8'd0, at);
        wr(8'hF1, 8'h04, e);
        wait_to(e + 16 * 255);
        rd(8'hFF, v, r); chk("R4 target 0 before 256 ticks", v, incs(e, r, 16, 0) & 15);
        wait_to(e + 16 * 300);
        rd(8'hFF, v, r); chk("R4 target 0 after 256 ticks", v, 1);
    endtask

    // R7: read on the same edge as an increment
    task automatic t_collision();
        logic [7:0] v;
        int at, e, r;
        do_reset();
        wr(8'hFC, 8'd1, at);
        wr(8'hF1, 8'h04, e);
        wait_to(16 * 6);
        rd(8'hFF, v, r); chk("R7 collision returns old", v, incs(e, r, 16, 1) & 15);
        rd(8'hFF, v, at); chk("R7 collision leaves 1", v, 1);
    endtask

    // R8: enable rising edge clears, enable held does not
    task automatic t_enable_edges();
        logic [7:0] v;
        int at, e0, e1, e2, r;
        do_reset();
        wr(8'hFA, 8'd1, at);
        wr(8'hFB, 8'd1, at);
        wr(8'hF1, 8'h01, e0);
        wait_to(e0 + 128 * 3 + 9);
        wr(8'hF1, 8'h03, e1);
        wait_to(e1 + 128 * 2 + 7);
        rd(8'hFD, v, r); chk("R8 held enable keeps count", v, incs(e0, r, 128, 1) & 15);
        rd(8'hFE, v, r); chk("R8 rising enable starts timer1", v, incs(e1, r, 128, 1) & 15);
        wait_to(r + 128 * 2);
        wr(8'hF1, 8'h00, at);
        wr(8'hF1, 8'h01, e2);
        rd(8'hFD, v, r); chk("R8 re-enable clears counter", v, 0);
    endtask

    // R9: disabled hold and prescaler phase continuity
    task automatic t_disable_hold();
        logic [7:0] v;
        int at, e, d, e2, r, held;
        do_reset();
        wr(8'hFC, 8'd2, at);
        wr(8'hF1, 8'h04, e);
        wait_to(e + 16 * 9 + 4);
        wr(8'hF1, 8'h00, d);
        held = incs(e, d + 1, 16, 2) & 15;
        wait_to(d + 200);
        rd(8'hFF, v, r); chk("R9 disabled counter holds", v, held);
        wait_to(r + 7);
        wr(8'hF1, 8'h04, e2);
        wait_to(e2 + 16 * 8 + 3);
        rd(8'hFF, v, r); chk("R9 prescaler phase kept", v, incs(e2, r, 16, 2) & 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_and_zero_reads();
        t_fast_divide();
        t_slow_divide();
        t_wrap();
        t_target_zero();
        t_collision();
        t_enable_edges();
        t_disable_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule